// File: doc/BRIEF.md
# Power-Down Wake-Up Event Controller

This block watches for wake-up events while the system sleeps and raises a wake request in the crystal clock domain. There are two sources, each with its own enable bit. The first is an aggregate GPIO interrupt: the OR of a group of FIFO and timestamp event lines that are already synchronous to the crystal clock. The second is a dedicated external wake pin that may change at any time. That pin passes through a multi-flop synchronizer. It counts as a wake event only after it has been seen low during power-down and then held high for a minimum number of crystal cycles.

The wake request is a level. Once raised, it stays high until the CPU acknowledges it or the power-down indication drops. A two-bit cause register records which sources fired during the current power-down period. It keeps its value after wake so that software can read it, and it clears when the next power-down period begins.

Top module: `pd_wake_ctrl`

## Requirements
- R1: While `pwr_down_i` is high and `wake_en_i[0]` is 1, any single bit of `evt_i` being high at a clock edge sets `wake_req_o` at that edge.
- R2: When `wake_en_i[0]` is 0, `evt_i` has no effect on `wake_req_o` or on `wake_cause_o[0]`.
- R3: While `pwr_down_i` is high, `wake_en_i[1]` is 1 and the pin has been seen low, holding `ext_wake_i` high sets `wake_req_o` exactly SYNC_STAGES+MIN_HIGH clock edges after the first edge that samples it high.
- R4: When `wake_en_i[1]` is 0, `ext_wake_i` has no effect on `wake_req_o` or on `wake_cause_o[1]`.
- R5: A pin that is already high when power-down begins causes no wake until it has gone low and then high again.
- R6: A high pulse on `ext_wake_i` that lasts fewer than MIN_HIGH clock edges causes no wake.
- R7: `wake_req_o` stays high until `cpu_ack_i` is sampled high; the request is then low after that edge, and an acknowledge takes priority over a new event at the same edge.
- R8: An acknowledge disarms the external pin, so a pin held high across the acknowledge does not raise the request again until it has gone low and then high.
- R9: At any edge where `pwr_down_i` is low, `wake_req_o` becomes 0, and no source can set it.
- R10: `wake_cause_o[0]` (GPIO) and `wake_cause_o[1]` (external pin) are sticky flags set by the matching source event. Both are reloaded with only the current events at the first edge of a power-down period, and they keep their value after power-down ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_xtal | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_EVT | FIFO and timestamp event lines, crystal-synchronous |
| ext_wake_i | input | 1 | Dedicated external wake pin, asynchronous |
| wake_en_i | input | 2 | Source enables: bit 0 GPIO aggregate, bit 1 external pin |
| pwr_down_i | input | 1 | High while the system is in power-down |
| cpu_ack_i | input | 1 | CPU acknowledge of the wake request |
| wake_req_o | output | 1 | Level wake request |
| wake_cause_o | output | 2 | Sticky cause flags: bit 0 GPIO, bit 1 external pin |

## Verification
On every cycle the bound checker enforces the lifetime of the request. It checks that the request drops after an acknowledge or outside power-down, and that it holds while neither occurs. It also checks that every rising request follows power-down with at least one enabled source and carries a non-zero cause. The bench's scenarios are needed for the rest: the exact latency through the synchronizer and the high-time qualifier, the rejection of short pulses, the rule that a pin already high at entry does not wake, re-arming after an acknowledge, and the retention of the cause flags. These behaviours depend on the history of the pin, so the bench checks them against its reference model over multi-cycle stimulus.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
   localparam int CAUSE_GPIO = 0;
   localparam int CAUSE_EXT  = 1;
   localparam int N_SRC      = 2;
   typedef logic [N_SRC-1:0] src_vec_t;
endpackage

// File: rtl/pd_wake_sync.sv
module pd_wake_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[0], d_i};
         end
      end else begin : g_deep
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pd_wake_ext_qual.sv
module pd_wake_ext_qual #(
   parameter int MIN_HIGH = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_i,
   input  logic ack_i,
   input  logic en_i,
   input  logic pin_s_i,
   output logic hit_o
);
   localparam int CW = $clog2(MIN_HIGH + 1);
   localparam logic [CW-1:0] CNT_TOP = CW'(MIN_HIGH - 1);

   logic          armed_q;
   logic [CW-1:0] hi_cnt_q;

   // armed once the pin is seen low inside power-down; ack disarms
   always_ff @(posedge clk) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= pd_i & ~ack_i & (armed_q | ~pin_s_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_cnt_q <= '0;
      else if (pd_i && armed_q && pin_s_i)
         hi_cnt_q <= (hi_cnt_q == CNT_TOP) ? hi_cnt_q : hi_cnt_q + 1'b1;
      else
         hi_cnt_q <= '0;
   end

   assign hit_o = en_i & pd_i & armed_q & pin_s_i & (hi_cnt_q == CNT_TOP);
endmodule

// File: rtl/pd_wake_req.sv
module pd_wake_req
   import pd_wake_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pd_i,
   input  logic     ack_i,
   input  src_vec_t hit_i,
   output logic     req_o,
   output src_vec_t cause_o
);
   logic pd_q;
   logic entry;

   assign entry = pd_i & ~pd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pd_q    <= 1'b0;
         req_o   <= 1'b0;
         cause_o <= '0;
      end else begin
         pd_q <= pd_i;
         if (!pd_i || ack_i) req_o <= 1'b0;
         else if (|hit_i)    req_o <= 1'b1;
         cause_o <= entry ? hit_i : (cause_o | hit_i);
      end
   end
endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
   import pd_wake_pkg::*;
#(
   parameter int N_EVT       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_HIGH    = 1
) (
   input  logic             clk_xtal,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_i,
   input  logic             ext_wake_i,
   input  logic [1:0]       wake_en_i,
   input  logic             pwr_down_i,
   input  logic             cpu_ack_i,
   output logic             wake_req_o,
   output logic [1:0]       wake_cause_o
);
   generate
      if (N_EVT < 1) begin : g_bad_evt
         $error("N_EVT must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_HIGH < 1) begin : g_bad_min
         $error("MIN_HIGH must be at least 1");
      end
   endgenerate

   logic     pin_s;
   src_vec_t hits;
   src_vec_t cause;

   pd_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_xtal),
      .rst_n (rst_n),
      .d_i   (ext_wake_i),
      .q_o   (pin_s)
   );

   pd_wake_ext_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
      .clk     (clk_xtal),
      .rst_n   (rst_n),
      .pd_i    (pwr_down_i),
      .ack_i   (cpu_ack_i),
      .en_i    (wake_en_i[CAUSE_EXT]),
      .pin_s_i (pin_s),
      .hit_o   (hits[CAUSE_EXT])
   );

   assign hits[CAUSE_GPIO] = pwr_down_i & wake_en_i[CAUSE_GPIO] & (|evt_i);

   pd_wake_req u_req (
      .clk     (clk_xtal),
      .rst_n   (rst_n),
      .pd_i    (pwr_down_i),
      .ack_i   (cpu_ack_i),
      .hit_i   (hits),
      .req_o   (wake_req_o),
      .cause_o (cause)
   );

   assign wake_cause_o = cause;
endmodule

// File: rtl/pd_wake_ctrl_chk.sv
module pd_wake_ctrl_chk (
   input logic       clk_xtal,
   input logic       rst_n,
   input logic [1:0] wake_en_i,
   input logic       pwr_down_i,
   input logic       cpu_ack_i,
   input logic       wake_req_o,
   input logic [1:0] wake_cause_o
);
   // R9
   req_clr_outside_pd_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      !pwr_down_i |=> !wake_req_o);

   // R7
   req_clr_on_ack_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      cpu_ack_i |=> !wake_req_o);

   // R7
   req_held_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      (wake_req_o && pwr_down_i && !cpu_ack_i) |=> wake_req_o);

   // R2
   req_needs_enable_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      $rose(wake_req_o) |-> ($past(wake_en_i) != 2'b00 && $past(pwr_down_i)));

   // R10
   req_has_cause_chk: assert property (@(posedge clk_xtal) disable iff (!rst_n)
      $rose(wake_req_o) |-> (wake_cause_o != 2'b00));
endmodule

bind pd_wake_ctrl pd_wake_ctrl_chk u_chk (
   .clk_xtal     (clk_xtal),
   .rst_n        (rst_n),
   .wake_en_i    (wake_en_i),
   .pwr_down_i   (pwr_down_i),
   .cpu_ack_i    (cpu_ack_i),
   .wake_req_o   (wake_req_o),
   .wake_cause_o (wake_cause_o)
);

// File: tb/pd_wake_ctrl_tb.sv
`timescale 1ns/1ps
module pd_wake_ctrl_tb;
   localparam int NE   = 6;
   localparam int SYNC = 2;
   localparam int MINH = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt = '0;
   logic          pin = 1'b0;
   logic [1:0]    en = 2'b00;
   logic          pd = 1'b0;
   logic          ack = 1'b0;
   logic          req;
   logic [1:0]    cause;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   pd_wake_ctrl #(.N_EVT(NE), .SYNC_STAGES(SYNC), .MIN_HIGH(MINH)) u_dut (
      .clk_xtal     (clk),
      .rst_n        (rst_n),
      .evt_i        (evt),
      .ext_wake_i   (pin),
      .wake_en_i    (en),
      .pwr_down_i   (pd),
      .cpu_ack_i    (ack),
      .wake_req_o   (req),
      .wake_cause_o (cause)
   );

   // behavioural reference model
   int pin_hist[$];
   bit m_arm, m_req, m_pdq;
   int m_cnt;
   bit [1:0] m_cause;

   always @(posedge clk) begin
      bit gh, eh, ps;
      if (!rst_n) begin
         pin_hist = {};
         for (int k = 0; k < SYNC; k++) pin_hist.push_back(0);
         m_arm = 0; m_req = 0; m_pdq = 0; m_cnt = 0; m_cause = 2'b00;
      end else begin
         ps = pin_hist[SYNC-1] != 0;
         gh = pd && en[0] && (evt != 0);
         eh = pd && en[1] && m_arm && ps && (m_cnt >= MINH-1);
         if (!pd || ack) m_req = 0;
         else if (gh || eh) m_req = 1;
         if (pd && !m_pdq) m_cause = {eh, gh};
         else              m_cause = m_cause | {eh, gh};
         if (pd && m_arm && ps) m_cnt = (m_cnt + 1 > MINH-1) ? MINH-1 : m_cnt + 1;
         else m_cnt = 0;
         m_arm = pd && !ack && (m_arm || !ps);
         m_pdq = pd;
         void'(pin_hist.pop_back());
         pin_hist.push_front(int'(pin));
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // advance one clock, then compare against the model away from the edge
   task automatic cyc();
      @(posedge clk);
      #2;
      chk(req == m_req, "R7 model wake_req", req, m_req);
      chk(cause == m_cause, "R10 model cause", cause, m_cause);
   endtask

   task automatic cycn(input int n);
      for (int k = 0; k < n; k++) cyc();
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      cycn(3);
      rst_n = 1'b1;
      cyc();
      chk(req == 1'b0, "R9 reset req", req, 0);
      chk(cause == 2'b00, "R10 reset cause", cause, 0);

      // GPIO source, each event line on its own
      en = 2'b01; pd = 1'b1;
      cycn(3);
      chk(req == 1'b0, "R1 idle in pd", req, 0);
      for (int i = 0; i < NE; i++) begin
         evt = NE'(1) << i;
         cyc();
         chk(req == 1'b1, "R1 event line wakes", req, 1);
         chk(cause[0] == 1'b1, "R10 gpio cause", cause[0], 1);
         cycn(2);
         chk(req == 1'b1, "R7 held until ack", req, 1);
         ack = 1'b1; evt = '0;
         cyc();
         chk(req == 1'b0, "R7 ack clears", req, 0);
         ack = 1'b0;
         cyc();
      end

      // ack has priority over a same-edge event
      evt = 6'b000100; ack = 1'b1;
      cyc();
      chk(req == 1'b0, "R7 ack beats event", req, 0);
      ack = 1'b0; evt = '0;
      cyc();

      // GPIO disabled
      en = 2'b00; evt = '1;
      cycn(4);
      chk(req == 1'b0, "R2 gpio disabled", req, 0);
      evt = '0;

      // new power-down period, external pin only
      pd = 1'b0; cyc();
      pd = 1'b1; en = 2'b10; cyc();
      chk(cause == 2'b00, "R10 cause cleared at entry", cause, 0);
      evt = '1; cycn(3);
      chk(cause[0] == 1'b0, "R2 gpio cause untouched", cause[0], 0);
      evt = '0; cycn(2);

      // short pulse of MINH-1 cycles
      pin = 1'b1; cycn(MINH-1);
      pin = 1'b0; cycn(8);
      chk(req == 1'b0, "R6 short pulse ignored", req, 0);

      // qualified pulse: latency SYNC+MINH edges
      pin = 1'b1;
      cycn(SYNC+MINH-1);
      chk(req == 1'b0, "R3 not early", req, 0);
      cyc();
      chk(req == 1'b1, "R3 wake at latency", req, 1);
      chk(cause == 2'b10, "R10 ext cause", cause, 2);

      // ack while pin stays high: disarmed
      ack = 1'b1; cyc(); ack = 1'b0;
      cycn(10);
      chk(req == 1'b0, "R8 no rewake while high", req, 0);
      pin = 1'b0; cycn(4);
      pin = 1'b1; cycn(SYNC+MINH);
      chk(req == 1'b1, "R8 rewake after low", req, 1);

      // leaving power-down
      pd = 1'b0; cyc();
      chk(req == 1'b0, "R9 exit clears", req, 0);
      chk(cause == 2'b10, "R10 cause retained", cause, 2);
      en = 2'b11; evt = '1; cycn(4);
      chk(req == 1'b0, "R9 no wake outside pd", req, 0);
      evt = '0;

      // pin high at entry
      en = 2'b10; pd = 1'b1; cycn(12);
      chk(req == 1'b0, "R5 high at entry ignored", req, 0);
      pin = 1'b0; cycn(4);
      pin = 1'b1; cycn(SYNC+MINH);
      chk(req == 1'b1, "R5 wake after low-high", req, 1);
      ack = 1'b1; cyc(); ack = 1'b0; pin = 1'b0; cycn(4);

      // external pin disabled
      en = 2'b01; pin = 1'b1; cycn(10);
      chk(req == 1'b0, "R4 pin disabled", req, 0);
      pin = 1'b0; cycn(3);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule